// File: doc/BRIEF.md
# Line-Locked Stretched CPU Clock Generator

This block derives a processor clock from a video-rate master clock. Each ordinary processor cycle is a fixed number of master periods: first a low phase, then a high phase. The processor clock has to stay in step with the display line. To make that happen, the last cycle of every line has a few extra master periods added to its high phase. A whole number of processor cycles then fills each line, and the processor clock stays phase-locked to it.

A master clock of about 14.318 MHz with the defaults gives a processor clock near 1.023 MHz. Each line holds 65 cycles, 64 ordinary ones of 14 ticks and one long one of 16. The low and high widths, the stretch, and the cycles per line are all parameters. An asymmetric split, such as 4 low and 8 high from a 12 MHz master, needs only a different set of parameter values.

There are four outputs:
- the processor phase clock;
- a one-tick enable that ends each processor cycle;
- a flag that marks the long cycle;
- a pulse on the first master tick of each line.

Top module: `lcs_clkgen`

## Requirements
- R1: While reset is held, and on the first master tick after it, the block sits at tick 0 of cycle 0. In that state `cpu_clk_o`=0, `cpu_en_o`=0, `long_cyc_o`=0 and `line_start_o`=1.
- R2: Every cycle other than the last of a line lasts LOW_TICKS+HIGH_TICKS master ticks (default 7+7). `cpu_clk_o` is 0 for the first LOW_TICKS ticks and 1 for the rest.
- R3: The last cycle of a line (index LINE_CYCLES-1, default 64) adds STRETCH_TICKS ticks (default 2) to its high phase. With the defaults it is 7 low and 9 high.
- R4: `cpu_en_o` is 1 on exactly the last master tick of every cycle, and on no other tick.
- R5: `long_cyc_o` is 1 on every tick of the last cycle of a line and 0 on every other tick.
- R6: `line_start_o` is 1 only on tick 0 of cycle 0. With the defaults it repeats every 64*14+16 = 912 master ticks.
- R7: With LOW_TICKS=4, HIGH_TICKS=8, STRETCH_TICKS=0 and LINE_CYCLES=3, every cycle is 4 low then 8 high, and the line repeats every 36 ticks.
- R8: Reset asserted at any point of a line restarts the block at tick 0 of cycle 0. Timing then continues exactly as after the first reset.
- R9: Outside reset, no low phase is shorter than LOW_TICKS and no high phase is shorter than HIGH_TICKS. No cycle exceeds LOW_TICKS+HIGH_TICKS+STRETCH_TICKS ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master (video-rate) clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_clk_o | output | 1 | Processor phase clock, low phase first |
| cpu_en_o | output | 1 | One-tick pulse on the last master tick of each processor cycle |
| long_cyc_o | output | 1 | High during the stretched cycle of each line |
| line_start_o | output | 1 | High on the first master tick of each line |

## Verification
The end of the long cycle is the one tick where both counters wrap together. On that tick the phase counter restarts while the cycle index returns to zero, and `cpu_en_o` and `long_cyc_o` are high together. On the following tick `line_start_o` must appear with the clock low.

The bench runs many whole lines and drops resets at random points, including right at that boundary. It compares every tick against a reference that is computed from the tick count since reset. It also measures the width of every phase.

// File: rtl/lcs_clkgen_pkg.sv
package lcs_clkgen_pkg;

    // Decoded outputs of the generator, gathered for a single assignment.
    typedef struct packed {
        logic cpu_clk;
        logic cpu_en;
        logic long_cyc;
        logic line_start;
    } lcs_taps_t;

endpackage

// File: rtl/lcs_phase_timer.sv
module lcs_phase_timer #(
    parameter int LOW_TICKS     = 7,
    parameter int HIGH_TICKS    = 7,
    parameter int STRETCH_TICKS = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic long_i,
    output logic hi_o,
    output logic last_o,
    output logic start_o
);

    localparam int MAX_LEN = LOW_TICKS + HIGH_TICKS + STRETCH_TICKS;
    localparam int TW      = (MAX_LEN > 2) ? $clog2(MAX_LEN) : 1;
    localparam logic [TW-1:0] END_SHORT = TW'(LOW_TICKS + HIGH_TICKS - 1);
    localparam logic [TW-1:0] END_LONG  = TW'(MAX_LEN - 1);
    localparam logic [TW-1:0] RISE_AT   = TW'(LOW_TICKS);

    typedef struct packed {
        logic [TW-1:0] tick;
        logic          hi;
    } phase_st_t;

    phase_st_t     st_d, st_q;
    logic [TW-1:0] end_tick;
    logic          wrap;

    always_comb begin
        end_tick = long_i ? END_LONG : END_SHORT;
        wrap     = (st_q.tick == end_tick);
        st_d     = st_q;
        st_d.tick = wrap ? '0 : st_q.tick + 1'b1;
        st_d.hi   = (st_d.tick >= RISE_AT);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign hi_o    = st_q.hi;
    assign last_o  = wrap;
    assign start_o = (st_q.tick == '0);

    assert_tick_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.tick <= END_LONG);

    assert_rise_point_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(st_q.hi) |-> st_q.tick == RISE_AT);

    assert_wrap_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wrap |=> !st_q.hi && st_q.tick == '0);

endmodule

// File: rtl/lcs_cycle_counter.sv
module lcs_cycle_counter #(
    parameter int LINE_CYCLES = 65
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic advance_i,
    output logic long_o,
    output logic first_o
);

    localparam int CW = (LINE_CYCLES > 2) ? $clog2(LINE_CYCLES) : 1;
    localparam logic [CW-1:0] LAST_IDX = CW'(LINE_CYCLES - 1);

    typedef struct packed {
        logic [CW-1:0] idx;
    } cyc_st_t;

    cyc_st_t cyc_d, cyc_q;

    always_comb begin
        cyc_d = cyc_q;
        if (advance_i) begin
            cyc_d.idx = (cyc_q.idx == LAST_IDX) ? '0 : cyc_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cyc_q <= '0;
        else         cyc_q <= cyc_d;
    end

    assign long_o  = (cyc_q.idx == LAST_IDX);
    assign first_o = (cyc_q.idx == '0);

    assert_idx_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cyc_q.idx <= LAST_IDX);

    assert_line_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        advance_i && long_o |=> first_o);

    assert_hold_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !advance_i |=> $stable(cyc_q.idx));

endmodule

// File: rtl/lcs_clkgen.sv
module lcs_clkgen
    import lcs_clkgen_pkg::*;
#(
    parameter int LOW_TICKS     = 7,
    parameter int HIGH_TICKS    = 7,
    parameter int STRETCH_TICKS = 2,
    parameter int LINE_CYCLES   = 65
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic cpu_clk_o,
    output logic cpu_en_o,
    output logic long_cyc_o,
    output logic line_start_o
);

    logic       phase_hi, phase_last, phase_start;
    logic       cyc_long, cyc_first;
    lcs_taps_t  taps;

    lcs_phase_timer #(
        .LOW_TICKS    (LOW_TICKS),
        .HIGH_TICKS   (HIGH_TICKS),
        .STRETCH_TICKS(STRETCH_TICKS)
    ) phase_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .long_i (cyc_long),
        .hi_o   (phase_hi),
        .last_o (phase_last),
        .start_o(phase_start)
    );

    lcs_cycle_counter #(
        .LINE_CYCLES(LINE_CYCLES)
    ) cycle_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .advance_i(phase_last),
        .long_o   (cyc_long),
        .first_o  (cyc_first)
    );

    always_comb begin
        taps.cpu_clk    = phase_hi;
        taps.cpu_en     = phase_last;
        taps.long_cyc   = cyc_long;
        taps.line_start = cyc_first && phase_start;
    end

    assign cpu_clk_o    = taps.cpu_clk;
    assign cpu_en_o     = taps.cpu_en;
    assign long_cyc_o   = taps.long_cyc;
    assign line_start_o = taps.line_start;

    assert_en_in_high_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cpu_en_o |-> cpu_clk_o);

    assert_fall_after_en_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(cpu_clk_o) |-> $past(cpu_en_o));

    assert_start_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        line_start_o |-> !cpu_clk_o && !long_cyc_o);

    assert_long_to_start_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cpu_en_o && long_cyc_o |=> line_start_o);

endmodule

// File: tb/lcs_clkgen_tb_top.sv
module lcs_clkgen_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic d_clk, d_en, d_long, d_ls;
    logic a_clk, a_en, a_long, a_ls;

    lcs_clkgen dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .cpu_clk_o(d_clk), .cpu_en_o(d_en), .long_cyc_o(d_long), .line_start_o(d_ls)
    );

    lcs_clkgen #(.LOW_TICKS(4), .HIGH_TICKS(8), .STRETCH_TICKS(0), .LINE_CYCLES(3)) dut_asym_i (
        .clk_i(clk), .rst_ni(rst_n),
        .cpu_clk_o(a_clk), .cpu_en_o(a_en), .long_cyc_o(a_long), .line_start_o(a_ls)
    );

    int checks = 0;
    int errors = 0;
    int m = 0;             // master ticks since reset release
    int since_mid = -1;    // ticks since a mid-run reset, -1 if none pending
    bit done = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) m <= 0;
        else        m <= m + 1;
    end

    // Expected {clk, en, long, line_start} at tick m for a given configuration.
    function automatic logic [3:0] expect_taps(int mm, int lo, int hi, int st, int n);
        int base, plen, p, cyc, t, len;
        base = lo + hi;
        plen = (n - 1) * base + base + st;
        p = mm % plen;
        if (p < (n - 1) * base) begin
            cyc = p / base; t = p % base; len = base;
        end else begin
            cyc = n - 1; t = p - (n - 1) * base; len = base + st;
        end
        return {t >= lo, t == len - 1, cyc == n - 1, p == 0};
    endfunction

    function automatic string tag_for(int bitpos, logic [3:0] e, int mm, int mid);
        if (mm == 0) return "R1";
        if (mid >= 0 && mid < 912) return "R8";
        case (bitpos)
            3: return e[1] ? "R3" : "R2";
            2: return "R4";
            1: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic cmp(string tag, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s at tick %0d: actual %b expected %b", tag, what, m, act, exp);
        end
    endtask

    // Phase-width tracking for R9 (main instance).
    int lo_run = 0, hi_run = 0;
    logic prev_clk = 1'b0;

    initial begin
        forever begin
            @(posedge clk);
            #3;
            if (!done) begin
                logic [3:0] e, ea, got, gota;
                e    = expect_taps(m, 7, 7, 2, 65);
                ea   = expect_taps(m, 4, 8, 0, 3);
                got  = {d_clk, d_en, d_long, d_ls};
                gota = {a_clk, a_en, a_long, a_ls};
                cmp(tag_for(3, e, m, since_mid), "cpu_clk", got[3], e[3]);
                cmp(tag_for(2, e, m, since_mid), "cpu_en", got[2], e[2]);
                cmp(tag_for(1, e, m, since_mid), "long_cyc", got[1], e[1]);
                cmp(tag_for(0, e, m, since_mid), "line_start", got[0], e[0]);
                for (int b = 0; b < 4; b++) cmp("R7", "asym output", gota[b], ea[b]);
                if (since_mid >= 0) since_mid++;
                // R9 run-length checks
                if (!rst_n || m == 0) begin
                    lo_run = 1; hi_run = 0; prev_clk = 1'b0;
                end else begin
                    if (prev_clk && !d_clk) begin
                        cmp("R9", "low phase min", lo_run >= 7, 1'b1);
                        cmp("R9", "high phase min", hi_run >= 7, 1'b1);
                        cmp("R9", "cycle max", (lo_run + hi_run) <= 16, 1'b1);
                        lo_run = 0; hi_run = 0;
                    end
                    if (d_clk) hi_run++; else lo_run++;
                    prev_clk = d_clk;
                end
            end
        end
    end

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_reset(int hold);
        @(negedge clk);
        rst_n = 1'b0;
        run(hold);
        rst_n = 1'b1;
        since_mid = 0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        run(4);
        rst_n = 1'b1;
        run(912 * 3 + 5);
        // random mid-line resets
        for (int i = 0; i < 8; i++) begin
            pulse_reset($urandom_range(1, 4));
            run($urandom_range(1, 2000));
        end
        // directed: reset landing at the end of the long cycle and at line start
        pulse_reset(1);
        run(910);
        pulse_reset(2);
        run(912);
        pulse_reset(1);
        run(912 * 4);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule